// File: doc/BRIEF.md
# Variable-length 16-bit instruction decoder

This block is the decode front end for a compact 16-bit RISC instruction set. It receives a stream of 16-bit instruction words from instruction memory, each tagged with its byte address and qualified by a valid strobe. It sorts the first word of each instruction into one of four classes: relative jump, one-operand, two-operand or illegal. It pulls out the register, mode, width and opcode fields, and works out from the addressing modes how many trailing words belong to the instruction.

The trailing words carry 16-bit memory addresses, index offsets or immediate constants. The block collects up to two of them, with the source word always ahead of the destination word. It then presents one complete decoded record for a single cycle. The record also holds the branch target of a jump and an estimate of the instruction's cost. That cost counts every memory access the instruction makes: instruction words fetched plus operand reads and writes.

The decoder accepts a word on every cycle in which the valid strobe is high. Idle cycles between words of one instruction are allowed. No execution, register contents or flags are handled here.

Top module: `vld_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0 and every record output is 0. A reset abandons any partly gathered instruction, so the next accepted word is decoded as a new first word.
- R2: A first word with bits [15:13] = 001 is a relative jump. It reports class 0, opcode = {0, bits [12:10]} (the condition), length 1 and cost 1. All register, mode and width fields are 0.
- R3: For a jump, `out_target` = word address + 2 + (bits [9:0] sign-extended and shifted left by one), modulo 2^16. Offset 0x3FF yields the word's own address, 0x200 reaches back 1024 bytes, and 0x1FF reaches forward 1022 bytes.
- R4: A first word with bits [15:10] = 000100 is a one-operand instruction. It reports class 1, opcode = {0, bits [9:7]}, byte flag = bit 6, source mode = bits [5:4] (the operand's mode) and destination register = bits [3:0]. The source register and destination mode are 0.
- R5: A first word with bits [15:12] >= 0100 is a two-operand instruction. It reports class 2, opcode = bits [15:12], source register = bits [11:8], destination mode = bit 7, byte flag = bit 6, source mode = bits [5:4] and destination register = bits [3:0].
- R6: Any other first word (bits [15:13] = 000 with bits [12:10] not 100) is illegal. It reports class 3, length 1 and cost 1, with all fields, extension words and the target at 0.
- R7: A source extension word is needed for a two-operand instruction whose source mode is 01, or whose source mode is 11 with source register 0. A destination extension word is needed for a two-operand instruction whose destination mode is 1. A one-operand instruction needs one extension word, reported as the destination extension, when its mode is 01, or 11 with register 0. The source extension arrives first. The length is 1 plus the number of extension words, and an unused extension output is 0.
- R8: `out_valid` is 0 while extension words are still outstanding. It pulses high for exactly one cycle per instruction, in the cycle after the edge that accepts the instruction's last word. Back-to-back single-word instructions give back-to-back pulses.
- R9: The cost `out_cycles` is the length plus the operand data accesses. For a two-operand instruction, add 1 for a nonzero source mode other than the immediate case (mode 11 with register 0), and add 2 for destination mode 1. For a one-operand instruction, add 2 for a nonzero mode other than the immediate case.
- R10: A cycle with `in_valid` low has no effect, whatever `in_word` and `in_addr` hold, whether it falls between instructions or between the words of one instruction.
- R11: Between pulses, all record outputs hold the last decoded instruction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The word on `in_word` is accepted this cycle |
| in_word | input | 16 | Instruction or extension word |
| in_addr | input | ADDR_W | Byte address of `in_word` |
| out_valid | output | 1 | One-cycle strobe: a complete record is present |
| out_class | output | 2 | 0 jump, 1 one-operand, 2 two-operand, 3 illegal |
| out_opcode | output | 4 | Opcode, or the jump condition |
| out_byte | output | 1 | Byte/word width flag |
| out_src_reg | output | 4 | Source register |
| out_src_mode | output | 2 | Source (or sole operand) addressing mode |
| out_dst_mode | output | 1 | Destination addressing mode |
| out_dst_reg | output | 4 | Destination (or sole operand) register |
| out_src_ext | output | 16 | Source extension word, or 0 |
| out_dst_ext | output | 16 | Destination extension word, or 0 |
| out_target | output | ADDR_W | Jump target, or 0 |
| out_addr | output | ADDR_W | Address of the first word |
| out_len | output | 2 | Instruction length in words |
| out_cycles | output | 3 | Memory-access cost estimate |

## Verification
Jumps are tried at several addresses with small positive, all-ones, most-negative and most-positive offsets. This separates correct sign extension and scaling from plain truncation, and shows the wrap at the top of the address space. One- and two-operand words are sent with every addressing mode, with register 0 and with nonzero registers. This tells the immediate case apart from the auto-increment case, and a source word from a destination word, including when both extension words are present. Illegal prefixes, back-to-back single-word instructions, idle cycles with garbage words inside and after an instruction, and a reset in the middle of gathering show that the sequencer counts only accepted words and holds its record between strobes.

// File: rtl/vld_pkg.sv
package vld_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned REG_W  = 4;
    localparam int unsigned OP_W   = 4;
    localparam int unsigned MODE_W = 2;
    localparam int unsigned COND_W = 3;
    localparam int unsigned OFS_W  = 10;
    localparam int unsigned LEN_W  = 2;
    localparam int unsigned CYC_W  = 3;

    // decode prefixes, positions fixed by the instruction set
    localparam logic [2:0] JUMP_PREFIX = 3'b001;
    localparam logic [5:0] ONE_PREFIX  = 6'b000100;
    localparam logic [3:0] TWO_MIN_OP  = 4'b0100;

    localparam logic [MODE_W-1:0] MODE_REG  = 2'b00;
    localparam logic [MODE_W-1:0] MODE_IDX  = 2'b01;
    localparam logic [MODE_W-1:0] MODE_INC  = 2'b11;
    localparam logic [REG_W-1:0]  PC_REG    = '0;

    typedef enum logic [1:0] {
        CLS_JUMP = 2'd0,
        CLS_ONE  = 2'd1,
        CLS_TWO  = 2'd2,
        CLS_BAD  = 2'd3
    } icls_e;

    // fields of a first word after classification
    typedef struct packed {
        icls_e              cls;
        logic [OP_W-1:0]    op;
        logic               bw;
        logic [REG_W-1:0]   sreg;
        logic [MODE_W-1:0]  smode;
        logic               dmode;
        logic [REG_W-1:0]   dreg;
        logic               need_s;
        logic               need_d;
        logic [OFS_W-1:0]   ofs;
    } hdr_t;

    // operand mode that pulls a trailing word from the stream
    function automatic logic mode_takes_word(input logic [MODE_W-1:0] mode,
                                             input logic [REG_W-1:0]  rnum);
        return (mode == MODE_IDX) || ((mode == MODE_INC) && (rnum == PC_REG));
    endfunction

endpackage

// File: rtl/vld_hdr_split.sv
module vld_hdr_split
    import vld_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              hdr
);

    logic [OP_W-1:0]   top_op;
    logic [COND_W-1:0] sub_tag;

    always_comb begin
        top_op  = word[WORD_W-1 -: OP_W];
        sub_tag = word[12:10];
        hdr     = '0;
        if (word[15:13] == JUMP_PREFIX) begin
            hdr.cls = CLS_JUMP;
            hdr.op  = {1'b0, sub_tag};
            hdr.ofs = word[OFS_W-1:0];
        end else if (top_op >= TWO_MIN_OP) begin
            hdr.cls    = CLS_TWO;
            hdr.op     = top_op;
            hdr.sreg   = word[11:8];
            hdr.dmode  = word[7];
            hdr.bw     = word[6];
            hdr.smode  = word[5:4];
            hdr.dreg   = word[3:0];
            hdr.need_s = mode_takes_word(word[5:4], word[11:8]);
            hdr.need_d = word[7];
        end else if (word[15:10] == ONE_PREFIX) begin
            hdr.cls    = CLS_ONE;
            hdr.op     = {1'b0, word[9:7]};
            hdr.bw     = word[6];
            hdr.smode  = word[5:4];
            hdr.dreg   = word[3:0];
            hdr.need_d = mode_takes_word(word[5:4], word[3:0]);
        end else begin
            hdr.cls = CLS_BAD;
        end
    end

endmodule

// File: rtl/vld_cost_calc.sv
module vld_cost_calc
    import vld_pkg::*;
(
    input  icls_e              cls,
    input  logic [MODE_W-1:0]  smode,
    input  logic [REG_W-1:0]   sreg,
    input  logic               dmode,
    input  logic [REG_W-1:0]   dreg,
    input  logic               need_s,
    input  logic               need_d,
    output logic [LEN_W-1:0]   ext_cnt,
    output logic [CYC_W-1:0]   cycles
);

    logic [CYC_W-1:0] data_acc;
    logic             two_src_mem;
    logic             one_mem;

    always_comb begin
        ext_cnt     = LEN_W'(need_s) + LEN_W'(need_d);
        // immediate operands arrive as the extension word: no data access
        two_src_mem = (smode != MODE_REG) && !((smode == MODE_INC) && (sreg == PC_REG));
        one_mem     = (smode != MODE_REG) && !((smode == MODE_INC) && (dreg == PC_REG));
        data_acc    = '0;
        unique case (cls)
            CLS_TWO: begin
                if (two_src_mem) data_acc = data_acc + CYC_W'(1);
                if (dmode)       data_acc = data_acc + CYC_W'(2);
            end
            CLS_ONE: begin
                if (one_mem)     data_acc = CYC_W'(2);
            end
            default: data_acc = '0;
        endcase
        cycles = CYC_W'(1) + CYC_W'(ext_cnt) + data_acc;
    end

endmodule

// File: rtl/vld_jump_calc.sv
module vld_jump_calc #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned OFS_W  = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] tgt
);

    localparam int unsigned PAD_W = ADDR_W - OFS_W - 1;

    logic [ADDR_W-1:0] byte_ofs;

    always_comb begin
        byte_ofs = {{PAD_W{ofs[OFS_W-1]}}, ofs, 1'b0};
        tgt      = addr + ADDR_W'(2) + byte_ofs;
    end

endmodule

// File: rtl/vld_decoder.sv
module vld_decoder
    import vld_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [WORD_W-1:0]    in_word,
    input  logic [ADDR_W-1:0]    in_addr,
    output logic                 out_valid,
    output logic [1:0]           out_class,
    output logic [OP_W-1:0]      out_opcode,
    output logic                 out_byte,
    output logic [REG_W-1:0]     out_src_reg,
    output logic [MODE_W-1:0]    out_src_mode,
    output logic                 out_dst_mode,
    output logic [REG_W-1:0]     out_dst_reg,
    output logic [WORD_W-1:0]    out_src_ext,
    output logic [WORD_W-1:0]    out_dst_ext,
    output logic [ADDR_W-1:0]    out_target,
    output logic [ADDR_W-1:0]    out_addr,
    output logic [LEN_W-1:0]     out_len,
    output logic [CYC_W-1:0]     out_cycles
);

    typedef struct packed {
        icls_e              cls;
        logic [OP_W-1:0]    op;
        logic               bw;
        logic [REG_W-1:0]   sreg;
        logic [MODE_W-1:0]  smode;
        logic               dmode;
        logic [REG_W-1:0]   dreg;
        logic [ADDR_W-1:0]  addr;
        logic [WORD_W-1:0]  sx;
        logic [WORD_W-1:0]  dx;
        logic [ADDR_W-1:0]  tgt;
        logic [LEN_W-1:0]   len;
        logic [CYC_W-1:0]   cyc;
    } rec_t;

    typedef struct packed {
        logic               busy;
        logic [LEN_W-1:0]   left;
        logic               src_wait;
        rec_t               cur;
        logic               o_vld;
        rec_t               out;
    } st_t;

    st_t               st_d;
    st_t               st_q;
    hdr_t              hdr_w;
    logic [LEN_W-1:0]  ext_w;
    logic [CYC_W-1:0]  cyc_w;
    logic [ADDR_W-1:0] tgt_w;
    logic              fin;

    vld_hdr_split u_split (
        .word (in_word),
        .hdr  (hdr_w)
    );

    vld_cost_calc u_cost (
        .cls     (hdr_w.cls),
        .smode   (hdr_w.smode),
        .sreg    (hdr_w.sreg),
        .dmode   (hdr_w.dmode),
        .dreg    (hdr_w.dreg),
        .need_s  (hdr_w.need_s),
        .need_d  (hdr_w.need_d),
        .ext_cnt (ext_w),
        .cycles  (cyc_w)
    );

    vld_jump_calc #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) u_jump (
        .addr (in_addr),
        .ofs  (hdr_w.ofs),
        .tgt  (tgt_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.o_vld = 1'b0;
        fin        = 1'b0;
        if (in_valid) begin
            if (!st_q.busy) begin
                // first word: capture fields, clear extension slots
                st_d.cur.cls   = hdr_w.cls;
                st_d.cur.op    = hdr_w.op;
                st_d.cur.bw    = hdr_w.bw;
                st_d.cur.sreg  = hdr_w.sreg;
                st_d.cur.smode = hdr_w.smode;
                st_d.cur.dmode = hdr_w.dmode;
                st_d.cur.dreg  = hdr_w.dreg;
                st_d.cur.addr  = in_addr;
                st_d.cur.sx    = '0;
                st_d.cur.dx    = '0;
                st_d.cur.tgt   = (hdr_w.cls == CLS_JUMP) ? tgt_w : '0;
                st_d.cur.len   = LEN_W'(1) + ext_w;
                st_d.cur.cyc   = cyc_w;
                st_d.left      = ext_w;
                st_d.src_wait  = hdr_w.need_s;
                if (ext_w == '0) begin
                    fin = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                end
            end else begin
                // trailing word: source slot fills before destination slot
                if (st_q.src_wait) begin
                    st_d.cur.sx   = in_word;
                    st_d.src_wait = 1'b0;
                end else begin
                    st_d.cur.dx   = in_word;
                end
                st_d.left = st_q.left - LEN_W'(1);
                if (st_q.left == LEN_W'(1)) begin
                    fin       = 1'b1;
                    st_d.busy = 1'b0;
                end
            end
        end
        if (fin) begin
            st_d.o_vld = 1'b1;
            st_d.out   = st_d.cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.o_vld;
    assign out_class    = st_q.out.cls;
    assign out_opcode   = st_q.out.op;
    assign out_byte     = st_q.out.bw;
    assign out_src_reg  = st_q.out.sreg;
    assign out_src_mode = st_q.out.smode;
    assign out_dst_mode = st_q.out.dmode;
    assign out_dst_reg  = st_q.out.dreg;
    assign out_src_ext  = st_q.out.sx;
    assign out_dst_ext  = st_q.out.dx;
    assign out_target   = st_q.out.tgt;
    assign out_addr     = st_q.out.addr;
    assign out_len      = st_q.out.len;
    assign out_cycles   = st_q.out.cyc;

endmodule

// File: rtl/vld_decoder_chk.sv
module vld_decoder_chk
    import vld_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               out_valid,
    input logic [1:0]         out_class,
    input logic [OP_W-1:0]    out_opcode,
    input logic [WORD_W-1:0]  out_src_ext,
    input logic [WORD_W-1:0]  out_dst_ext,
    input logic [ADDR_W-1:0]  out_addr,
    input logic [LEN_W-1:0]   out_len,
    input logic [CYC_W-1:0]   out_cycles
);

    // R8
    strobe_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R2
    jump_single_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 2'd0) |-> (out_len == 2'd1 && out_cycles == 3'd1 && out_opcode[3] == 1'b0));

    // R6
    illegal_bare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 2'd3) |-> (out_len == 2'd1 && out_cycles == 3'd1 && out_src_ext == '0 && out_dst_ext == '0));

    // R7
    len_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= 2'd1 && out_len <= 2'd3));

    // R7
    one_op_no_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 2'd1) |-> (out_len <= 2'd2 && out_src_ext == '0));

    // R9
    cost_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cycles >= 3'(out_len)));

    // R11
    record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_class) && $stable(out_addr) && $stable(out_cycles) && $stable(out_len)));

endmodule

bind vld_decoder vld_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/vld_decoder_test.sv
module vld_decoder_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic [15:0] in_addr = '0;
    logic        out_valid;
    logic [1:0]  out_class;
    logic [3:0]  out_opcode;
    logic        out_byte;
    logic [3:0]  out_src_reg;
    logic [1:0]  out_src_mode;
    logic        out_dst_mode;
    logic [3:0]  out_dst_reg;
    logic [15:0] out_src_ext;
    logic [15:0] out_dst_ext;
    logic [15:0] out_target;
    logic [15:0] out_addr;
    logic [1:0]  out_len;
    logic [2:0]  out_cycles;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vld_decoder #(.ADDR_W(16)) uut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [86:0] actual_rec();
        return {out_class, out_opcode, out_byte, out_src_reg, out_src_mode, out_dst_mode,
                out_dst_reg, out_src_ext, out_dst_ext, out_target, out_addr, out_len, out_cycles};
    endfunction

    // expected record, from the requirement text
    function automatic logic [86:0] model(input logic [15:0] h, input logic [15:0] a,
                                          input logic [15:0] e0, input logic [15:0] e1);
        logic [1:0]  c;
        logic [3:0]  op, sr, dr;
        logic        bw, dm, ns, nd;
        logic [1:0]  sm;
        logic [15:0] sx, dx, tg;
        int          n, cy;
        c = 2'd3; op = '0; sr = '0; dr = '0; bw = 0; dm = 0; ns = 0; nd = 0;
        sm = '0; sx = '0; dx = '0; tg = '0; cy = 0;
        if (h[15:13] == 3'b001) begin
            c  = 2'd0;
            op = {1'b0, h[12:10]};
            tg = a + 16'd2 + {{5{h[9]}}, h[9:0], 1'b0};
        end else if (h[15:12] >= 4'd4) begin
            c = 2'd2; op = h[15:12]; sr = h[11:8]; dm = h[7]; bw = h[6]; sm = h[5:4]; dr = h[3:0];
            ns = (sm == 2'd1) || (sm == 2'd3 && sr == 4'd0);
            nd = dm;
            if (sm != 2'd0 && !(sm == 2'd3 && sr == 4'd0)) cy += 1;
            if (dm) cy += 2;
        end else if (h[15:10] == 6'b000100) begin
            c = 2'd1; op = {1'b0, h[9:7]}; bw = h[6]; sm = h[5:4]; dr = h[3:0];
            nd = (sm == 2'd1) || (sm == 2'd3 && dr == 4'd0);
            if (sm != 2'd0 && !(sm == 2'd3 && dr == 4'd0)) cy += 2;
        end
        if (ns) sx = e0;
        if (nd) dx = ns ? e1 : e0;
        n  = 1 + int'(ns) + int'(nd);
        cy = cy + n;
        return {c, op, bw, sr, sm, dm, dr, sx, dx, tg, a, 2'(n), 3'(cy)};
    endfunction

    // called at a falling edge; leaves the bench at the falling edge of the strobe
    task automatic run_instr(input string req, input logic [15:0] h, input logic [15:0] a,
                             input logic [15:0] e0, input logic [15:0] e1, input int gap,
                             input int exp_len, input int exp_cyc, input logic [15:0] exp_tgt);
        logic [15:0] w [3];
        logic [86:0] exp_r;
        w = '{h, e0, e1};
        exp_r = model(h, a, e0, e1);
        for (int k = 0; k < exp_len; k++) begin
            if (k > 0) begin
                for (int g = 0; g < gap; g++) begin
                    in_valid = 1'b0;
                    in_word  = 16'hDEAD ^ 16'(g);
                    in_addr  = 16'hBEEF;
                    @(negedge clk);
                    check(out_valid == 1'b0, "R10", "strobe during idle gap", 128'(out_valid), 128'(0));
                end
            end
            in_valid = 1'b1;
            in_word  = w[k];
            in_addr  = a + 16'(2 * k);
            @(negedge clk);
            if (k < exp_len - 1)
                check(out_valid == 1'b0, "R8", "strobe while words pending", 128'(out_valid), 128'(0));
        end
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R8", "strobe after last word", 128'(out_valid), 128'(1));
        check(out_len == 2'(exp_len), req, "length", 128'(out_len), 128'(exp_len));
        check(out_cycles == 3'(exp_cyc), "R9", "cost", 128'(out_cycles), 128'(exp_cyc));
        check(out_target == exp_tgt, req, "target", 128'(out_target), 128'(exp_tgt));
        check(actual_rec() == exp_r, req, "record", 128'(actual_rec()), 128'(exp_r));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && actual_rec() == '0, "R1", "outputs in reset", 128'(actual_rec()), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && actual_rec() == '0, "R1", "outputs after reset", 128'(actual_rec()), 128'(0));
    endtask

    task automatic t_jumps();
        run_instr("R2", 16'h2805, 16'h0100, 16'h0, 16'h0, 0, 1, 1, 16'h010C);
        check(out_opcode == 4'd2, "R2", "condition", 128'(out_opcode), 128'(2));
        run_instr("R3", 16'h3FFF, 16'h0200, 16'h0, 16'h0, 0, 1, 1, 16'h0200);
        run_instr("R3", 16'h2200, 16'h0400, 16'h0, 16'h0, 0, 1, 1, 16'h0002);
        run_instr("R3", 16'h2DFF, 16'hFFF0, 16'h0, 16'h0, 0, 1, 1, 16'h03F0);
    endtask

    task automatic t_single();
        run_instr("R4", 16'h12C7, 16'h1000, 16'h0, 16'h0, 0, 1, 1, 16'h0);
        check(out_class == 2'd1 && out_opcode == 4'd5 && out_byte && out_dst_reg == 4'd7,
              "R4", "one-operand fields", 128'(actual_rec()), 128'(0));
        run_instr("R7", 16'h1115, 16'h1010, 16'h1234, 16'h0, 3, 2, 4, 16'h0);
        check(out_dst_ext == 16'h1234 && out_src_ext == 16'h0, "R7", "one-operand extension slot",
              128'(out_dst_ext), 128'(16'h1234));
        run_instr("R9", 16'h1230, 16'h1020, 16'h7FFF, 16'h0, 0, 2, 2, 16'h0);
        run_instr("R9", 16'h10E4, 16'h1030, 16'h0, 16'h0, 0, 1, 3, 16'h0);
    endtask

    task automatic t_two();
        run_instr("R5", 16'h5309, 16'h2000, 16'h0, 16'h0, 0, 1, 1, 16'h0);
        check(out_class == 2'd2 && out_opcode == 4'd5 && out_src_reg == 4'd3 && out_dst_reg == 4'd9,
              "R5", "two-operand fields", 128'(actual_rec()), 128'(0));
        run_instr("R7", 16'hA692, 16'h2010, 16'hAAAA, 16'h5555, 2, 3, 6, 16'h0);
        check(out_src_ext == 16'hAAAA && out_dst_ext == 16'h5555, "R7", "source before destination",
              128'({out_src_ext, out_dst_ext}), 128'(32'hAAAA5555));
        run_instr("R7", 16'h40FF, 16'h2020, 16'h0042, 16'h0C00, 0, 3, 5, 16'h0);
        run_instr("R9", 16'hF86A, 16'h2030, 16'h0, 16'h0, 0, 1, 2, 16'h0);
        run_instr("R7", 16'h6184, 16'h2040, 16'h0BEE, 16'h0, 1, 2, 4, 16'h0);
        check(out_dst_ext == 16'h0BEE && out_src_ext == 16'h0, "R7", "destination-only extension",
              128'(out_dst_ext), 128'(16'h0BEE));
        run_instr("R9", 16'h7531, 16'h2050, 16'h0, 16'h0, 0, 1, 2, 16'h0);
    endtask

    task automatic t_illegal();
        run_instr("R6", 16'h0000, 16'h3000, 16'h0, 16'h0, 0, 1, 1, 16'h0);
        run_instr("R6", 16'h1400, 16'h3002, 16'h0, 16'h0, 0, 1, 1, 16'h0);
        run_instr("R6", 16'h0C00, 16'h3004, 16'h0, 16'h0, 0, 1, 1, 16'h0);
        check(out_class == 2'd3, "R6", "illegal class", 128'(out_class), 128'(3));
    endtask

    task automatic t_back_to_back();
        run_instr("R8", 16'h2805, 16'h4000, 16'h0, 16'h0, 0, 1, 1, 16'h400C);
        run_instr("R8", 16'h5309, 16'h4002, 16'h0, 16'h0, 0, 1, 1, 16'h0);
        run_instr("R8", 16'h1115, 16'h4004, 16'h9999, 16'h0, 0, 2, 4, 16'h0);
    endtask

    task automatic t_hold();
        logic [86:0] kept;
        run_instr("R11", 16'hA692, 16'h5000, 16'h1111, 16'h2222, 0, 3, 6, 16'h0);
        kept = actual_rec();
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b0;
            in_word  = 16'h1115 ^ 16'(i * 16'h0101);
            in_addr  = 16'(i);
            @(negedge clk);
            check(out_valid == 1'b0, "R10", "no strobe without valid", 128'(out_valid), 128'(0));
            check(actual_rec() == kept, "R11", "record held", 128'(actual_rec()), 128'(kept));
        end
    endtask

    task automatic t_reset_abandon();
        in_valid = 1'b1; in_word = 16'hA692; in_addr = 16'h6000;
        @(negedge clk);
        in_word = 16'h1111; in_addr = 16'h6002;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(out_valid == 1'b0 && actual_rec() == '0, "R1", "cleared by reset", 128'(actual_rec()), 128'(0));
        run_instr("R1", 16'h2805, 16'h0100, 16'h0, 16'h0, 0, 1, 1, 16'h010C);
    endtask

    initial begin
        t_reset();
        t_jumps();
        t_single();
        t_two();
        t_illegal();
        t_back_to_back();
        t_hold();
        t_reset_abandon();
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule